// File: doc/BRIEF.md
# Randomly Gated Shift-Ring Noise Generator

This block surrounds a cryptographic core with a bank of independent circular shift rings whose only job is to burn switching power in a pattern an observer cannot predict. Each ring is a chain of equal-length shift-register segments. The last segment's output loops back into the first. Every ring starts out holding alternating ones and zeros, so each shift toggles every flip-flop in that ring.

Each ring advances only when its own bit of an externally supplied random vector is high. It also needs the shared run input, which follows the activity of the crypto core on the same clock, to be high. As a result, the number of rings switching in any cycle varies at random. A synchronous preload input restores the alternating pattern in a single cycle and overrides shifting. Each ring's output bit is brought out as a tap for observation.

Top module: `noise_ring_bank`

## Requirements
- R1: After reset, every ring holds the alternating pattern: bit k of a ring, counted from the input end of its first segment, is 1 when k is odd. The tap is the last bit of the ring, so every tap reads 1.
- R2: When run is 1, preload is 0 and rnd[i] is 1, ring i rotates by one position at the clock edge. Because the pattern alternates, tap[i] inverts in the following cycle.
- R3: When rnd[i] is 0 and preload is 0, ring i holds its contents and tap[i] is unchanged, whatever the other bits of rnd are.
- R4: When run is 0 and preload is 0, no ring moves, whatever the value of rnd.
- R5: preload = 1 reloads the alternating pattern into every ring at the next edge, so every tap reads 1. This holds regardless of run or rnd, and preload takes priority over shifting.
- R6: Rotation preserves the number of ones in a ring. Over NUM_SEG*SEG_LEN consecutive enabled shifts of one ring, its tap reads 1 in exactly half of those cycles, and the ring is back at its starting tap value.
- R7: Rings are independent. A ring's state depends only on its own enable history since the last preload.
- R8: SEG_LEN is an elaboration parameter limited to 16 or 64. The ring length is NUM_SEG*SEG_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the crypto core |
| rst | input | 1 | Synchronous active-high reset, loads the pattern |
| run | input | 1 | High while the crypto core is active |
| preload | input | 1 | Synchronous reload of the alternating pattern |
| rnd | input | NUM_RING | Per-ring random enable bits |
| tap | output | NUM_RING | Last bit of each ring |

## Verification
The vector walk uses single-ring enables, which confirm that only the addressed ring inverts its tap. Mixed masks tell independent rings apart from rings that share state. A full mask with run low separates the global hold from the per-ring gate. A preload applied with a scattered enable mask shows that the reload wins over rotation, and a preload applied with run low shows that the reload does not depend on run. A long run of a single enabled ring for one full ring length confirms that the ones count is kept and that the ring wraps back to its starting value.

// File: rtl/noise_ring_pkg.sv
package noise_ring_pkg;
  typedef struct packed {
    logic load;     // reload alternating pattern
    logic advance;  // rings may rotate where their random bit allows
  } ringStrobe_t;
endpackage

// File: rtl/noise_ring_ctrl.sv
module noise_ring_ctrl
  import noise_ring_pkg::*;
(
  input  logic        rst,
  input  logic        run,
  input  logic        preload,
  output ringStrobe_t strobe
);
  always_comb begin
    strobe.load    = rst | preload;
    strobe.advance = run & ~rst & ~preload;
  end
endmodule

// File: rtl/noise_ring_seg.sv
module noise_ring_seg #(
  parameter int SEG_LEN = 16
) (
  input  logic clk,
  input  logic load,
  input  logic shift,
  input  logic serIn,
  output logic serOut
);
  logic [SEG_LEN-1:0] bits;
  logic [SEG_LEN-1:0] pattern;

  always_comb begin
    for (int j = 0; j < SEG_LEN; j++) pattern[j] = j[0];
  end

  always_ff @(posedge clk) begin
    if (load)       bits <= pattern;
    else if (shift) bits <= {bits[SEG_LEN-2:0], serIn};
  end

  assign serOut = bits[SEG_LEN-1];
endmodule

// File: rtl/noise_ring_path.sv
module noise_ring_path
  import noise_ring_pkg::*;
#(
  parameter int NUM_RING = 16,
  parameter int NUM_SEG  = 36,
  parameter int SEG_LEN  = 16
) (
  input  logic                clk,
  input  ringStrobe_t         strobe,
  input  logic [NUM_RING-1:0] rnd,
  output logic [NUM_RING-1:0] tap
);
  localparam int LEN_OK = (SEG_LEN == 16 || SEG_LEN == 64) ? 1 : 0;

  generate
    if (LEN_OK == 0) begin : g_badLen
      initial $display("noise_ring_path: SEG_LEN must be 16 or 64");
    end
    for (genvar r = 0; r < NUM_RING; r++) begin : g_ring
      logic [NUM_SEG:0] link;
      logic             stepRing;
      assign stepRing = strobe.advance & rnd[r];
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        noise_ring_seg #(.SEG_LEN(SEG_LEN)) u_seg (
          .clk   (clk),
          .load  (strobe.load),
          .shift (stepRing),
          .serIn (link[s]),
          .serOut(link[s+1])
        );
      end
      assign link[0] = link[NUM_SEG];
      assign tap[r]  = link[NUM_SEG];
    end
  endgenerate
endmodule

// File: rtl/noise_ring_bank.sv
module noise_ring_bank
  import noise_ring_pkg::*;
#(
  parameter int NUM_RING = 16,
  parameter int NUM_SEG  = 36,
  parameter int SEG_LEN  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                preload,
  input  logic [NUM_RING-1:0] rnd,
  output logic [NUM_RING-1:0] tap
);
  ringStrobe_t strobe;

  noise_ring_ctrl u_ctrl (
    .rst    (rst),
    .run    (run),
    .preload(preload),
    .strobe (strobe)
  );

  noise_ring_path #(
    .NUM_RING(NUM_RING),
    .NUM_SEG (NUM_SEG),
    .SEG_LEN (SEG_LEN)
  ) u_path (
    .clk   (clk),
    .strobe(strobe),
    .rnd   (rnd),
    .tap   (tap)
  );
endmodule

// File: rtl/noise_ring_bank_chk.sv
module noise_ring_bank_chk #(
  parameter int NUM_RING = 16,
  parameter int SEG_LEN  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                run,
  input logic                preload,
  input logic [NUM_RING-1:0] rnd,
  input logic [NUM_RING-1:0] tap
);
  initial begin
    a_r8_seg_len: assert (SEG_LEN == 16 || SEG_LEN == 64);
  end

  // R1 / R5: a reset or a preload leaves every tap at 1
  a_r5_preload_ones: assert property (@(posedge clk)
    (rst | preload) |=> (tap == {NUM_RING{1'b1}}));

  // R4: run low holds every ring
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !preload) |=> $stable(tap));

  generate
    for (genvar i = 0; i < NUM_RING; i++) begin : g_chk
      // R2: an enabled ring inverts its tap
      a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
        (run && !preload && rnd[i]) |=> (tap[i] != $past(tap[i])));
      // R3: a ring with its random bit low holds
      a_r3_gate_hold: assert property (@(posedge clk) disable iff (rst)
        (!preload && !rnd[i]) |=> $stable(tap[i]));
    end
  endgenerate
endmodule

bind noise_ring_bank noise_ring_bank_chk #(
  .NUM_RING(NUM_RING),
  .SEG_LEN (SEG_LEN)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .run    (run),
  .preload(preload),
  .rnd    (rnd),
  .tap    (tap)
);

// File: tb/tb_noise_ring_bank.sv
module tb_noise_ring_bank;
  localparam int NR  = 4;
  localparam int NS  = 3;
  localparam int SL  = 16;
  localparam int LEN = NS * SL;
  localparam int NV  = 10;

  // {run, preload, rnd[3:0], expected tap[3:0]}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'b0001, 4'b1110},  // R2 single ring
    {1'b1, 1'b0, 4'b0011, 4'b1101},  // R2/R7 mixed
    {1'b0, 1'b0, 4'b1111, 4'b1101},  // R4 run low
    {1'b1, 1'b0, 4'b1000, 4'b0101},  // R3 others hold
    {1'b1, 1'b1, 4'b0110, 4'b1111},  // R5 priority over shift
    {1'b1, 1'b0, 4'b1111, 4'b0000},  // R2 all rings
    {1'b1, 1'b0, 4'b0000, 4'b0000},  // R3 none enabled
    {1'b0, 1'b1, 4'b0000, 4'b1111},  // R5 preload with run low
    {1'b1, 1'b0, 4'b1010, 4'b0101},  // R7 independent
    {1'b1, 1'b0, 4'b0101, 4'b0000}   // R7 independent
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          preload = 1'b0;
  logic [NR-1:0] rnd = '0;
  logic [NR-1:0] tap;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  noise_ring_bank #(.NUM_RING(NR), .NUM_SEG(NS), .SEG_LEN(SL)) dut (
    .clk(clk), .rst(rst), .run(run), .preload(preload), .rnd(rnd), .tap(tap)
  );

  task automatic check(input string req, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic p, input logic [NR-1:0] m);
    run = r; preload = p; rnd = m;
    @(negedge clk);
  endtask

  initial begin
    int ones;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", tap, 4'b1111);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][9], VEC[v][8], VEC[v][7:4]);
      check("R2-R5/R7 vector", tap, VEC[v][3:0]);
    end

    // R5: preload with all rings enabled
    step(1'b1, 1'b1, 4'b1111);
    check("R5", tap, 4'b1111);

    // R6: one full ring length on ring 2 only
    ones = 0;
    for (int c = 0; c < LEN; c++) begin
      step(1'b1, 1'b0, 4'b0100);
      if (tap[2]) ones++;
    end
    checks++;
    if (ones != LEN / 2) begin
      failures++;
      $display("FAIL R6 ones actual=%0d expected=%0d", ones, LEN / 2);
    end
    check("R6 wrap", tap, 4'b1111);

    // R4: long idle with noisy rnd
    step(1'b1, 1'b0, 4'b0011);
    for (int c = 0; c < 8; c++) step(1'b0, 1'b0, 4'(c * 5));
    check("R4", tap, 4'b1100);

    // R1: reset mid-run restores the pattern
    rst = 1'b1;
    step(1'b1, 1'b0, 4'b1111);
    rst = 1'b0;
    check("R1 reset", tap, 4'b1111);

    // R3: ring 0 never enabled over many cycles
    for (int c = 0; c < 7; c++) step(1'b1, 1'b0, 4'b1110);
    check("R3", tap, 4'b0001);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule